// File: doc/BRIEF.md
# Shared-Link Packet Receiver

This block receives a single packet sent to this station over a shared open-drain parallel link. The link has a request line, an acknowledge line, a control line and eight data lines. All of them idle high and are pulled low by whichever station drives them. The block reads request, control and data. It drives only the acknowledge line, through a drive-low enable. Choosing which station uses the link, and sending, are done elsewhere.

A receive attempt starts with a pulse on `start_i`. The block then polls for an address mark that carries its own address and acknowledges it. After that it takes two bytes per handshake: one when request falls and one when request rises. Accepted bytes leave as a valid/byte stream, and the final stored byte is flagged as last. The packet ends when control is high at the rise of request. The attempt then finishes with a one-cycle `done_o` and a signed 16-bit status. The status is either the byte count or a negative error code. Every wait has a timeout that reloads each time the wait begins.

Top module: `lnk_rx`

## Requirements
- R1: After reset, `ack_drive_o`, `done_o` and `byte_valid_o` are all 0.
- R2: An address mark is a sample with control high, request low and data equal to `own_addr_i`. This mark makes the block drive acknowledge low. A mark carrying any other address is never acknowledged, and polling continues.
- R3: A sample is used only when the request and control levels agree over two consecutive clocks. If request toggles every clock, nothing is ever acknowledged.
- R4: Acknowledge for the address mark stays driven until request is seen high, and is then released.
- R5: In each data handshake, acknowledge is driven after request is seen low, and released after request is seen high. The byte present at the fall of request is output before the byte present at its rise.
- R6: Control high at the rise of request marks end of packet. The first byte of that handshake is a dummy and is neither counted nor output. If its second byte is 0x00, the status is the number of data bytes handshaked, which is two per earlier handshake.
- R7: If the end-of-packet byte is not 0x00, the status is -3 (0xFFFD). Bytes already accepted are still output.
- R8: Only the first `max_len_i` data bytes are output. With an odd maximum, only the first byte of the pair that reaches it is kept. Later handshakes still complete without output, and the status still counts them, so it may exceed the maximum.
- R9: If no valid address mark is seen in TIMEOUT+1 polling cycles, the status is -1 (0xFFFF). `done_o` then rises TIMEOUT+3 cycles after the start pulse.
- R10: A timeout after the address mark ends the attempt with status equal to the number of data bytes in completed handshakes.
- R11: The timeout count reloads at the start of every wait, so a packet whose gaps each stay under TIMEOUT completes, however long it is in total.
- R12: `done_o` is a one-cycle pulse. `status_o` is valid with it, and acknowledge is released at that point. The last stored byte, if there is one, is presented in the same cycle with `byte_last_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one receive attempt (accepted when idle) |
| own_addr_i | input | DATA_W | Station address to match |
| max_len_i | input | LEN_W | Maximum number of bytes to output |
| req_n_i | input | 1 | Request line level (low = asserted) |
| ctl_i | input | 1 | Control line level |
| data_i | input | DATA_W | Data line levels |
| ack_drive_o | output | 1 | 1 pulls the acknowledge line low |
| byte_valid_o | output | 1 | Output byte strobe |
| byte_o | output | DATA_W | Output byte |
| byte_last_o | output | 1 | Marks the final stored byte |
| done_o | output | 1 | One-cycle end-of-attempt pulse |
| status_o | output | 16 | Signed status: byte count, -1 or -3 |

## Verification
A state machine stuck in the wrong wait state shows up as an acknowledge level that does not follow request within two or three clocks. The sender model then stalls, and the attempt ends as a timeout with a status that is visibly wrong. A faulty byte counter or keep decision appears as soon as the packet finishes. The sweep over maximum length and packet length compares the emitted byte list, the position of the last flag and the status against arithmetic expectations, so off-by-one errors at odd and even limits show up on the first affected packet. Timing faults in the timer appear as a `done_o` that comes outside its expected cycle window, or as a spurious timeout during a slow packet.

// File: rtl/lnk_rx_pkg.sv
package lnk_rx_pkg;
  localparam int STAT_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AREL, ST_WLO, ST_WHI, ST_PUSH2, ST_FIN
  } rx_state_e;

  localparam logic [STAT_W-1:0] STATUS_NOMARK = 16'hFFFF;  // -1
  localparam logic [STAT_W-1:0] STATUS_PROTO  = 16'hFFFD;  // -3
endpackage

// File: rtl/lnk_rx_sample.sv
module lnk_rx_sample #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_n_i,
  input  logic              ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_n_o,
  output logic              ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stable_o
);
  localparam int CW = 2;

  logic [CW-1:0]     c1_q, c2_q;
  logic [DATA_W-1:0] d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= '1;
      c2_q <= '1;
      d1_q <= '1;
    end else begin
      c1_q <= {req_n_i, ctl_i};
      c2_q <= c1_q;
      d1_q <= data_i;
    end
  end

  // older control read must match the newer one
  assign stable_o = (c1_q == c2_q);
  assign req_n_o  = c1_q[1];
  assign ctl_o    = c1_q[0];
  assign data_o   = d1_q;
endmodule

// File: rtl/lnk_rx_timer.sv
module lnk_rx_timer #(
  parameter int TIMEOUT = 65535
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] RELOAD = TW'(TIMEOUT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= RELOAD;
    else if (load_i)                cnt_q <= RELOAD;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = tick_i && (cnt_q == '0);
endmodule

// File: rtl/lnk_rx_emit.sv
module lnk_rx_emit #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              flush_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              last_o
);
  // one byte held back so the final one can carry the last flag
  logic [DATA_W-1:0] hold_q, out_q;
  logic              hv_q, vld_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
      hv_q   <= 1'b0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      if (push_i) begin
        if (hv_q) begin
          vld_q <= 1'b1;
          out_q <= hold_q;
        end
        hold_q <= byte_i;
        hv_q   <= 1'b1;
      end else if (flush_i) begin
        if (hv_q) begin
          vld_q  <= 1'b1;
          out_q  <= hold_q;
          last_q <= 1'b1;
        end
        hv_q <= 1'b0;
      end
    end
  end

  assign valid_o = vld_q;
  assign byte_o  = out_q;
  assign last_o  = last_q;
endmodule

// File: rtl/lnk_rx.sv
module lnk_rx
  import lnk_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 8,
  parameter int TIMEOUT = 65535
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] own_addr_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              req_n_i,
  input  logic              ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_drive_o,
  output logic              byte_valid_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_last_o,
  output logic              done_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int CNT_W = STAT_W;

  logic              s_req_n, s_ctl, s_stb;
  logic [DATA_W-1:0] s_dat;
  logic              t_load, t_tick, t_exp;
  logic              hit, waiting;
  logic              push, flush;
  logic [DATA_W-1:0] push_byte;
  logic [CNT_W-1:0]  max_ext;

  rx_state_e         state_q, state_d;
  logic              ack_q, ack_d, k2_q, k2_d, done_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [DATA_W-1:0] b1_q, b1_d, b2_q, b2_d;

  lnk_rx_sample #(.DATA_W(DATA_W)) u_sample (
    .clk_i, .rst_ni, .req_n_i, .ctl_i, .data_i,
    .req_n_o(s_req_n), .ctl_o(s_ctl), .data_o(s_dat), .stable_o(s_stb)
  );

  lnk_rx_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i, .rst_ni, .load_i(t_load), .tick_i(t_tick), .expired_o(t_exp)
  );

  lnk_rx_emit #(.DATA_W(DATA_W)) u_emit (
    .clk_i, .rst_ni, .push_i(push), .byte_i(push_byte), .flush_i(flush),
    .valid_o(byte_valid_o), .byte_o(byte_o), .last_o(byte_last_o)
  );

  assign max_ext = CNT_W'(max_len_i);
  assign waiting = state_q inside {ST_ADDR, ST_AREL, ST_WLO, ST_WHI};

  always_comb begin
    unique case (state_q)
      ST_ADDR: hit = s_stb && s_ctl && !s_req_n && (s_dat == own_addr_i);
      ST_AREL: hit = s_stb && s_req_n;
      ST_WLO:  hit = s_stb && !s_req_n;
      ST_WHI:  hit = s_stb && s_req_n;
      default: hit = 1'b0;
    endcase
  end

  assign t_tick = waiting && !hit;

  always_comb begin
    state_d   = state_q;
    ack_d     = ack_q;
    cnt_d     = cnt_q;
    stat_d    = stat_q;
    b1_d      = b1_q;
    b2_d      = b2_q;
    k2_d      = k2_q;
    push      = 1'b0;
    push_byte = b1_q;
    flush     = 1'b0;
    t_load    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        t_load  = 1'b1;
        cnt_d   = '0;
        state_d = ST_ADDR;
      end
      ST_ADDR: if (hit) begin
        ack_d   = 1'b1;
        t_load  = 1'b1;
        state_d = ST_AREL;
      end else if (t_exp) begin
        stat_d  = STATUS_NOMARK;
        state_d = ST_FIN;
      end
      ST_AREL: if (hit) begin
        ack_d   = 1'b0;
        t_load  = 1'b1;
        state_d = ST_WLO;
      end else if (t_exp) begin
        ack_d   = 1'b0;
        stat_d  = cnt_q;
        state_d = ST_FIN;
      end
      ST_WLO: if (hit) begin
        b1_d    = s_dat;
        ack_d   = 1'b1;
        t_load  = 1'b1;
        state_d = ST_WHI;
      end else if (t_exp) begin
        stat_d  = cnt_q;
        state_d = ST_FIN;
      end
      ST_WHI: if (hit) begin
        ack_d  = 1'b0;
        t_load = 1'b1;
        if (s_ctl) begin
          // end of packet: first byte is a dummy, second must be zero
          stat_d  = (s_dat == '0) ? cnt_q : STATUS_PROTO;
          state_d = ST_FIN;
        end else begin
          push    = (cnt_q < max_ext);
          b2_d    = s_dat;
          k2_d    = ((cnt_q + 1'b1) < max_ext);
          cnt_d   = cnt_q + CNT_W'(2);
          state_d = ST_PUSH2;
        end
      end else if (t_exp) begin
        ack_d   = 1'b0;
        stat_d  = cnt_q;
        state_d = ST_FIN;
      end
      ST_PUSH2: begin
        push      = k2_q;
        push_byte = b2_q;
        state_d   = ST_WLO;
      end
      ST_FIN: begin
        flush   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      cnt_q   <= '0;
      stat_q  <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      k2_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      cnt_q   <= cnt_d;
      stat_q  <= stat_d;
      b1_q    <= b1_d;
      b2_q    <= b2_d;
      k2_q    <= k2_d;
      done_q  <= (state_q == ST_FIN);
    end
  end

  assign ack_drive_o = ack_q;
  assign done_o      = done_q;
  assign status_o    = stat_q;

  // R12: acknowledge is released whenever the attempt reports
  p_ack_low_at_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ack_drive_o);
  // R12: last flag only comes out together with done
  p_last_with_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && byte_last_o) |-> done_o);
  // R12: done is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5: acknowledge is only driven after request was seen low
  p_ack_rise_after_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_drive_o) |-> !$past(s_req_n));
  // R4: acknowledge is released only on seen request release or on exit
  p_ack_fall_after_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_drive_o) |-> ($past(s_req_n) || state_q == ST_FIN));
endmodule

// File: tb/lnk_rx_tb.sv
module lnk_rx_tb;
  localparam int TO   = 30;
  localparam logic [7:0] OWN = 8'h5C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] max_len = 8'd0;
  logic       req_n = 1'b1, ctl = 1'b1;
  logic [7:0] data = 8'hFF;
  logic       ack_drive, bvalid, blast, done;
  logic [7:0] bdata;
  logic [15:0] status;

  int n_cmp = 0, n_bad = 0;

  // monitor state
  logic [7:0] rx_buf [0:63];
  int  rx_n, last_cnt, last_idx, cyc_done, cyc;
  bit  done_seen, ack_seen;
  logic [15:0] got_status;

  always #2 clk = ~clk;

  lnk_rx #(.DATA_W(8), .LEN_W(8), .TIMEOUT(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .own_addr_i(OWN),
    .max_len_i(max_len), .req_n_i(req_n), .ctl_i(ctl), .data_i(data),
    .ack_drive_o(ack_drive), .byte_valid_o(bvalid), .byte_o(bdata),
    .byte_last_o(blast), .done_o(done), .status_o(status)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bvalid) begin
      if (rx_n < 64) rx_buf[rx_n] = bdata;
      if (blast) begin last_cnt = last_cnt + 1; last_idx = rx_n; end
      rx_n = rx_n + 1;
    end
    if (done && !done_seen) begin
      done_seen = 1; got_status = status; cyc_done = cyc;
    end
    if (ack_drive) ack_seen = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int run, input int k);
    return 8'((k * 29 + run * 7 + 1) & 255);
  endfunction

  task automatic clr_mon();
    rx_n = 0; last_cnt = 0; last_idx = -1; done_seen = 0; ack_seen = 0;
    cyc = 0; cyc_done = -1; got_status = '0;
  endtask

  task automatic wait_ack(input logic lvl, output bit ok);
    ok = 0;
    for (int i = 0; i < 3 * TO; i++) begin
      @(negedge clk);
      if (ack_drive == lvl) begin ok = 1; break; end
      if (done_seen) break;
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 6 * TO && !done_seen; i++) @(negedge clk);
  endtask

  task automatic idle_bus();
    req_n = 1'b1; ctl = 1'b1; data = 8'hFF;
    repeat (4) @(negedge clk);
  endtask

  // start pulse with the given address mark on the lines
  task automatic begin_rx(input logic [7:0] mark);
    @(negedge clk);
    clr_mon();
    start = 1'b1; data = mark; ctl = 1'b1; req_n = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // send address mark and pairs; mode 0 = EOP, 1 = stall low, 2 = stall high
  task automatic send(input int run, input int pairs, input int gap,
                      input int mode, input logic [7:0] eop_b);
    bit ok;
    begin_rx(OWN);
    wait_ack(1'b1, ok);
    ctl = 1'b0; req_n = 1'b1;
    wait_ack(1'b0, ok);
    for (int p = 0; p < pairs; p++) begin
      repeat (gap) @(negedge clk);
      data = pat(run, 2 * p); req_n = 1'b0;
      wait_ack(1'b1, ok);
      data = pat(run, 2 * p + 1); req_n = 1'b1;
      wait_ack(1'b0, ok);
    end
    if (mode == 0) begin
      data = 8'hA7; req_n = 1'b0;
      wait_ack(1'b1, ok);
      data = eop_b; ctl = 1'b1; req_n = 1'b1;
    end else if (mode == 2) begin
      data = 8'h3C; req_n = 1'b0;
      wait_ack(1'b1, ok);
    end
    wait_done();
  endtask

  task automatic check_stream(input string req, input int run, input int mx,
                              input int pairs, input int exp_stat);
    int exp_n, errs;
    exp_n = (mx < 2 * pairs) ? mx : 2 * pairs;
    chk({req, " done seen"}, int'(done_seen), 1);
    chk({req, " status"}, int'(got_status), exp_stat & 16'hFFFF);
    chk({req, " byte count"}, rx_n, exp_n);
    errs = 0;
    for (int k = 0; k < exp_n && k < rx_n && k < 64; k++)
      if (rx_buf[k] != pat(run, k)) errs++;
    chk({req, " byte content/order R5"}, errs, 0);
    chk("R12 last flag count", last_cnt, exp_n > 0 ? 1 : 0);
    if (exp_n > 0) chk("R12 last flag position", last_idx, exp_n - 1);
    chk("R12 ack released after done", int'(ack_drive), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int run;
    clr_mon();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ack in reset", int'(ack_drive), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 valid in reset", int'(bvalid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ack after reset", int'(ack_drive), 0);

    // R6 R8 R5: sweep maximum length against packet length
    run = 0;
    for (int mx = 0; mx < 8; mx++) begin
      for (int pairs = 0; pairs < 5; pairs++) begin
        max_len = 8'(mx);
        send(run, pairs, (mx + pairs) % 3, 0, 8'h00);
        check_stream("R6 R8 sweep", run, mx, pairs, 2 * pairs);
        idle_bus();
        run++;
      end
    end

    // R7: bad end-of-packet byte
    max_len = 8'd8;
    send(run, 3, 1, 0, 8'h11);
    check_stream("R7 bad EOP", run, 8, 3, 16'hFFFD);
    idle_bus(); run++;

    // R11: each gap below timeout, total much longer
    send(run, 4, TO - 6, 0, 8'h00);
    check_stream("R11 reload", run, 8, 4, 8);
    idle_bus(); run++;

    // R10: stall waiting for request low after two pairs
    send(run, 2, 0, 1, 8'h00);
    check_stream("R10 stall low", run, 8, 2, 4);
    idle_bus(); run++;

    // R10: stall with request held low after three pairs
    send(run, 3, 2, 2, 8'h00);
    check_stream("R10 stall high", run, 8, 3, 6);
    chk("R10 ack was driven before stall", int'(ack_seen), 1);
    idle_bus(); run++;

    // R2 R9: mark with a foreign address is ignored, then -1
    begin_rx(OWN ^ 8'h01);
    wait_done();
    chk("R9 status no mark", int'(got_status), 16'hFFFF);
    chk("R2 foreign address not acked", int'(ack_seen), 0);
    chk("R9 done not early", int'(cyc_done >= TO), 1);
    chk("R9 done not late", int'(cyc_done <= TO + 6), 1);
    chk("R2 no output bytes", rx_n, 0);
    idle_bus();

    // R3: request toggling every clock never yields a sample
    @(negedge clk);
    clr_mon();
    start = 1'b1; data = OWN; ctl = 1'b1; req_n = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6 * TO && !done_seen; i++) begin
      req_n = ~req_n;
      @(negedge clk);
    end
    chk("R3 unstable never acked", int'(ack_seen), 0);
    chk("R3 status timeout", int'(got_status), 16'hFFFF);
    idle_bus();

    // R2: after the ignored attempts a proper packet still works
    send(run, 2, 0, 0, 8'h00);
    check_stream("R2 own address", run, 8, 2, 4);
    idle_bus();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule